// File: doc/BRIEF.md
# ASID-Tagged Set-Associative Translation Buffer

This block translates a virtual address into a physical address for one access. It holds a small set-associative array of translation entries. Each entry carries a virtual page number, an 8-bit address-space tag, a physical page number and a 4-bit attribute. Every way is read at the index taken from the low virtual-page-number bits, and all ways are compared in parallel. The lookup path from the address, access kind and privilege inputs to the result outputs is purely combinational, so a result can be used in the same cycle.

A ring map register holds four address-space tags, one per privilege ring. An entry only counts as a hit when its tag appears in that register. The byte position of the tag gives the ring of the page. The result is a physical address, read/write/execute rights, a cache mode and a 6-bit fault cause, where 0 means success. Entries and the ring map are written through synchronous write ports. A synchronous active-low reset invalidates every entry and loads the ring map with its default. Page-table walking and refill policy live outside the block.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses, and the ring map holds tag 1 in ring 0, tag 2 in ring 1, tag 3 in ring 2 and tag 4 in ring 3 (byte i, bits [8i+7:8i], holds ring i).
- R2: An entry whose tag is 0 never matches, even when its page number equals the lookup page.
- R3: The ring of a matching entry is the lowest byte index of the ring map equal to the entry's tag. An entry whose tag is in no byte is not a hit. A ring map write takes effect for lookups after the clock edge that captures it.
- R4: When two or more ways hit, the cause is 17 for a fetch and 25 for a load or store.
- R5: When no way hits, the cause is 16 for a fetch and 24 for a load or store. Access kind encoding: 0 load, 1 store, 2 and 3 fetch.
- R6: When exactly one way hits and its ring is below the privilege input, the cause is 18 for a fetch and 26 for a load or store. This check comes before the rights check.
- R7: An attribute below 12 grants read, its bit 0 grants execute and its bit 1 grants write, and bits [3:2] give the cache mode (0 bypass, 1 write-back, 2 write-through). The cache output uses these codes and 3 for isolate.
- R8: Attribute 13 grants read and write with cache mode 3 (isolate). Attributes 12, 14 and 15 grant nothing.
- R9: Loads and stores never report execute rights, and fetches never report read or write rights. An access without the right it needs gives cause 28 for a load, 29 for a store and 20 for a fetch.
- R10: On success the physical address is the entry's physical page number above the low 12 virtual-address bits. Whenever the cause is non-zero, the address, the rights and the cache mode are all 0.
- R11: A write at a clock edge replaces the entry at the given way and index. An entry is only found when its index equals the low two bits of its page number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_wr_en | input | 1 | Entry write strobe |
| ent_wr_way | input | 2 | Way to write |
| ent_wr_idx | input | 2 | Entry index within the way |
| ent_wr_vpn | input | 20 | Virtual page number to store |
| ent_wr_asid | input | 8 | Address-space tag to store (0 = invalid) |
| ent_wr_ppn | input | 20 | Physical page number to store |
| ent_wr_attr | input | 4 | Attribute to store |
| ring_wr_en | input | 1 | Ring map write strobe |
| ring_wr_map | input | 32 | New ring map, byte i for ring i |
| look_vaddr | input | 32 | Virtual address to translate |
| look_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| look_priv | input | 2 | Current privilege level |
| look_paddr | output | 32 | Translated physical address |
| look_rd | output | 1 | Read right |
| look_wr | output | 1 | Write right |
| look_ex | output | 1 | Execute right |
| look_cache | output | 2 | Cache mode |
| look_cause | output | 6 | Fault cause, 0 on success |

## Verification
On every cycle the assertions check the properties that hold for any contents. A successful result always has the right its access kind needs and none of the rights of the other side. A faulting result is all zero. The page offset passes through unchanged. The cause code always belongs to the side of the access. Isolate mode only appears with read and write on the data side. The first lookup after reset misses. Behaviour that depends on stored contents can only be shown by the bench's scenarios: which way hits, ring resolution through the ring map, duplicate tags in the ring map, multiple-hit detection, privilege ordering, and the full attribute decode.

// File: rtl/asid_tlb_pkg.sv
// Shared types, cause codes and attribute decode for the translation buffer.
// Assumes a 4-bit attribute and four privilege rings.
package asid_tlb_pkg;

    localparam int RING_CNT = 4;
    localparam int RING_W   = 2;
    localparam int ATTR_W   = 4;
    localparam int CAUSE_W  = 6;

    typedef enum logic [1:0] {
        KIND_LOAD   = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_FETCH  = 2'd2,
        KIND_FETCH2 = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        CM_BYPASS  = 2'd0,
        CM_WBACK   = 2'd1,
        CM_WTHRU   = 2'd2,
        CM_ISOLATE = 2'd3
    } cache_mode_t;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        ex;
        cache_mode_t mode;
    } rights_t;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 6'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_I_MISS  = 6'd16;
    localparam logic [CAUSE_W-1:0] CAUSE_I_MULTI = 6'd17;
    localparam logic [CAUSE_W-1:0] CAUSE_I_PRIV  = 6'd18;
    localparam logic [CAUSE_W-1:0] CAUSE_I_DENY  = 6'd20;
    localparam logic [CAUSE_W-1:0] CAUSE_D_MISS  = 6'd24;
    localparam logic [CAUSE_W-1:0] CAUSE_D_MULTI = 6'd25;
    localparam logic [CAUSE_W-1:0] CAUSE_D_PRIV  = 6'd26;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_DENY = 6'd28;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_DENY = 6'd29;

    // Turn a raw attribute into rights and a cache mode, before side masking.
    function automatic rights_t decode_attr(input logic [ATTR_W-1:0] attr);
        rights_t r;
        r = '0;
        if (attr < 4'd12) begin
            r.rd   = 1'b1;
            r.ex   = attr[0];
            r.wr   = attr[1];
            r.mode = cache_mode_t'(attr[3:2]);
        end else if (attr == 4'd13) begin
            r.rd   = 1'b1;
            r.wr   = 1'b1;
            r.mode = CM_ISOLATE;
        end
        return r;
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
// Entry storage: one register bank per way, written one entry at a time.
// Every way is read at the same index. Reset clears all fields, which
// leaves every tag at 0, so every entry is invalid.
module tlb_entry_store #(
    parameter int WAYS    = 4,
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int ATTR_W  = 4,
    parameter int WAY_W   = 2,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [VPN_W-1:0]  rd_vpn  [WAYS],
    output logic [ASID_W-1:0] rd_asid [WAYS],
    output logic [PPN_W-1:0]  rd_ppn  [WAYS],
    output logic [ATTR_W-1:0] rd_attr [WAYS]
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [VPN_W-1:0]  vpn_q  [ENTRIES];
        logic [ASID_W-1:0] asid_q [ENTRIES];
        logic [PPN_W-1:0]  ppn_q  [ENTRIES];
        logic [ATTR_W-1:0] attr_q [ENTRIES];
        logic              this_way;

        assign this_way = wr_en && (wr_way == WAY_W'(w));

        // Clear this way on reset, otherwise replace the addressed entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    vpn_q[e]  <= '0;
                    asid_q[e] <= '0;
                    ppn_q[e]  <= '0;
                    attr_q[e] <= '0;
                end
            end else if (this_way) begin
                vpn_q[wr_idx]  <= wr_vpn;
                asid_q[wr_idx] <= wr_asid;
                ppn_q[wr_idx]  <= wr_ppn;
                attr_q[wr_idx] <= wr_attr;
            end
        end

        assign rd_vpn[w]  = vpn_q[rd_idx];
        assign rd_asid[w] = asid_q[rd_idx];
        assign rd_ppn[w]  = ppn_q[rd_idx];
        assign rd_attr[w] = attr_q[rd_idx];
    end

endmodule

// File: rtl/tlb_ring_reg.sv
// Ring map register: byte i holds the address-space tag for privilege ring i.
// Reset loads tag i+1 into byte i.
module tlb_ring_reg #(
    parameter int ASID_W = 8,
    parameter int RINGS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [RINGS*ASID_W-1:0] wr_map,
    output logic [RINGS*ASID_W-1:0] map_q
);

    // Load the default map on reset, otherwise take a full-width write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RINGS; i++) begin
                map_q[i*ASID_W +: ASID_W] <= ASID_W'(i + 1);
            end
        end else if (wr_en) begin
            map_q <= wr_map;
        end
    end

endmodule

// File: rtl/tlb_way_match.sv
// Per-way tag compare: the entry hits when its tag is non-zero, its page
// number equals the lookup page, and its tag is present in the ring map.
// The ring reported is the lowest matching byte.
module tlb_way_match #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int RINGS  = 4,
    parameter int RING_W = 2
) (
    input  logic [VPN_W-1:0]        look_vpn,
    input  logic [VPN_W-1:0]        ent_vpn,
    input  logic [ASID_W-1:0]       ent_asid,
    input  logic [RINGS*ASID_W-1:0] ring_map,
    output logic                    hit,
    output logic [RING_W-1:0]       ring
);

    logic in_map;

    // Scan ring bytes from the top so that the lowest match wins.
    always_comb begin
        in_map = 1'b0;
        ring   = '0;
        for (int i = RINGS - 1; i >= 0; i--) begin
            if (ring_map[i*ASID_W +: ASID_W] == ent_asid) begin
                in_map = 1'b1;
                ring   = RING_W'(i);
            end
        end
    end

    assign hit = (ent_asid != '0) && (ent_vpn == look_vpn) && in_map;

endmodule

// File: rtl/tlb_hit_resolve.sv
// Combines the per-way results. It counts hits, selects the single hitting
// way, applies the privilege and rights checks, and forms the outcome.
// Assumes the selected fields are meaningful only when exactly one way hits.
module tlb_hit_resolve
    import asid_tlb_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int PPN_W      = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int PADDR_W    = 32
) (
    input  logic [WAYS-1:0]       hit_vec,
    input  logic [RING_W-1:0]     ring   [WAYS],
    input  logic [PPN_W-1:0]      ppn    [WAYS],
    input  logic [ATTR_W-1:0]     attr   [WAYS],
    input  logic [1:0]            kind,
    input  logic [RING_W-1:0]     priv,
    input  logic [PAGE_SHIFT-1:0] page_off,
    output logic [PADDR_W-1:0]    paddr,
    output logic                  rd,
    output logic                  wr,
    output logic                  ex,
    output logic [1:0]            cache,
    output logic [CAUSE_W-1:0]    cause
);

    localparam int CNT_W = $clog2(WAYS + 1);

    logic [CNT_W-1:0]  n_hits;
    logic [RING_W-1:0] sel_ring;
    logic [PPN_W-1:0]  sel_ppn;
    logic [ATTR_W-1:0] sel_attr;
    acc_kind_t         kind_e;
    logic              is_fetch;
    rights_t           raw_r;
    rights_t           eff_r;
    logic              granted;
    logic              pass;

    assign kind_e   = acc_kind_t'(kind);
    assign is_fetch = kind[1];

    // Count hits and OR together the fields of the hitting ways.
    always_comb begin
        n_hits   = '0;
        sel_ring = '0;
        sel_ppn  = '0;
        sel_attr = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                n_hits   = n_hits + CNT_W'(1);
                sel_ring = sel_ring | ring[w];
                sel_ppn  = sel_ppn | ppn[w];
                sel_attr = sel_attr | attr[w];
            end
        end
    end

    // Decode the attribute and drop the rights of the other side.
    always_comb begin
        raw_r = decode_attr(sel_attr);
        eff_r = raw_r;
        if (is_fetch) begin
            eff_r.rd = 1'b0;
            eff_r.wr = 1'b0;
        end else begin
            eff_r.ex = 1'b0;
        end
        unique case (kind_e)
            KIND_LOAD:  granted = eff_r.rd;
            KIND_STORE: granted = eff_r.wr;
            default:    granted = eff_r.ex;
        endcase
    end

    // Pick the fault by priority: multiple hit, miss, privilege, rights.
    always_comb begin
        pass  = 1'b0;
        cause = CAUSE_NONE;
        if (n_hits > CNT_W'(1)) begin
            cause = is_fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
        end else if (n_hits == '0) begin
            cause = is_fetch ? CAUSE_I_MISS : CAUSE_D_MISS;
        end else if (sel_ring < priv) begin
            cause = is_fetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
        end else if (!granted) begin
            if (is_fetch) begin
                cause = CAUSE_I_DENY;
            end else if (kind_e == KIND_STORE) begin
                cause = CAUSE_ST_DENY;
            end else begin
                cause = CAUSE_LD_DENY;
            end
        end else begin
            pass = 1'b1;
        end
    end

    assign paddr = pass ? {sel_ppn, page_off} : '0;
    assign rd    = pass && eff_r.rd;
    assign wr    = pass && eff_r.wr;
    assign ex    = pass && eff_r.ex;
    assign cache = pass ? eff_r.mode : CM_BYPASS;

endmodule

// File: rtl/asid_tlb.sv
// Top of the tagged translation buffer. It wires together the entry store,
// the ring map register, one tag compare per way and the hit resolver.
// Lookup is combinational; writes and reset act at the rising clock edge.
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter  int NUM_WAYS    = 4,
    parameter  int WAY_ENTRIES = 4,
    parameter  int VADDR_W     = 32,
    parameter  int PAGE_SHIFT  = 12,
    parameter  int PPN_W       = 20,
    parameter  int ASID_W      = 8,
    localparam int VPN_W       = VADDR_W - PAGE_SHIFT,
    localparam int PADDR_W     = PPN_W + PAGE_SHIFT,
    localparam int WAY_W       = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int IDX_W       = (WAY_ENTRIES > 1) ? $clog2(WAY_ENTRIES) : 1,
    localparam int MAP_W       = RING_CNT * ASID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ent_wr_en,
    input  logic [WAY_W-1:0]   ent_wr_way,
    input  logic [IDX_W-1:0]   ent_wr_idx,
    input  logic [VPN_W-1:0]   ent_wr_vpn,
    input  logic [ASID_W-1:0]  ent_wr_asid,
    input  logic [PPN_W-1:0]   ent_wr_ppn,
    input  logic [ATTR_W-1:0]  ent_wr_attr,
    input  logic               ring_wr_en,
    input  logic [MAP_W-1:0]   ring_wr_map,
    input  logic [VADDR_W-1:0] look_vaddr,
    input  logic [1:0]         look_kind,
    input  logic [RING_W-1:0]  look_priv,
    output logic [PADDR_W-1:0] look_paddr,
    output logic               look_rd,
    output logic               look_wr,
    output logic               look_ex,
    output logic [1:0]         look_cache,
    output logic [CAUSE_W-1:0] look_cause
);

    logic [VPN_W-1:0]    look_vpn;
    logic [IDX_W-1:0]    look_idx;
    logic [MAP_W-1:0]    ring_map;
    logic [VPN_W-1:0]    e_vpn  [NUM_WAYS];
    logic [ASID_W-1:0]   e_asid [NUM_WAYS];
    logic [PPN_W-1:0]    e_ppn  [NUM_WAYS];
    logic [ATTR_W-1:0]   e_attr [NUM_WAYS];
    logic [NUM_WAYS-1:0] way_hit;
    logic [RING_W-1:0]   way_ring [NUM_WAYS];

    assign look_vpn = look_vaddr[VADDR_W-1:PAGE_SHIFT];
    assign look_idx = look_vpn[IDX_W-1:0];

    tlb_entry_store #(
        .WAYS    (NUM_WAYS),
        .ENTRIES (WAY_ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .ASID_W  (ASID_W),
        .ATTR_W  (ATTR_W),
        .WAY_W   (WAY_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ent_wr_en),
        .wr_way  (ent_wr_way),
        .wr_idx  (ent_wr_idx),
        .wr_vpn  (ent_wr_vpn),
        .wr_asid (ent_wr_asid),
        .wr_ppn  (ent_wr_ppn),
        .wr_attr (ent_wr_attr),
        .rd_idx  (look_idx),
        .rd_vpn  (e_vpn),
        .rd_asid (e_asid),
        .rd_ppn  (e_ppn),
        .rd_attr (e_attr)
    );

    tlb_ring_reg #(
        .ASID_W (ASID_W),
        .RINGS  (RING_CNT)
    ) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ring_wr_en),
        .wr_map (ring_wr_map),
        .map_q  (ring_map)
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_match
        tlb_way_match #(
            .VPN_W  (VPN_W),
            .ASID_W (ASID_W),
            .RINGS  (RING_CNT),
            .RING_W (RING_W)
        ) u_match (
            .look_vpn (look_vpn),
            .ent_vpn  (e_vpn[w]),
            .ent_asid (e_asid[w]),
            .ring_map (ring_map),
            .hit      (way_hit[w]),
            .ring     (way_ring[w])
        );
    end

    tlb_hit_resolve #(
        .WAYS       (NUM_WAYS),
        .PPN_W      (PPN_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .PADDR_W    (PADDR_W)
    ) u_resolve (
        .hit_vec  (way_hit),
        .ring     (way_ring),
        .ppn      (e_ppn),
        .attr     (e_attr),
        .kind     (look_kind),
        .priv     (look_priv),
        .page_off (look_vaddr[PAGE_SHIFT-1:0]),
        .paddr    (look_paddr),
        .rd       (look_rd),
        .wr       (look_wr),
        .ex       (look_ex),
        .cache    (look_cache),
        .cause    (look_cause)
    );

endmodule

// File: rtl/asid_tlb_checker.sv
// Checker for the translation buffer: properties that hold for any stored
// contents, sampled at each rising edge outside reset.
module asid_tlb_checker #(
    parameter int VADDR_W    = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int PADDR_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VADDR_W-1:0] look_vaddr,
    input logic [1:0]         look_kind,
    input logic [PADDR_W-1:0] look_paddr,
    input logic               look_rd,
    input logic               look_wr,
    input logic               look_ex,
    input logic [1:0]         look_cache,
    input logic [5:0]         look_cause
);

    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (look_cause == 6'd16 || look_cause == 6'd24));

    assert_cause_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        look_kind[1] |-> (look_cause inside {6'd0, 6'd16, 6'd17, 6'd18, 6'd20}));

    assert_cause_side_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !look_kind[1] |-> (look_cause inside {6'd0, 6'd24, 6'd25, 6'd26, 6'd28, 6'd29}));

    assert_read_below12_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (look_cause == 6'd0 && !look_kind[1]) |-> look_rd);

    assert_isolate_data_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (look_cause == 6'd0 && look_cache == 2'd3) |-> (!look_kind[1] && look_rd && look_wr));

    assert_side_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (look_cause == 6'd0) |-> (look_kind[1] ? (!look_rd && !look_wr) : !look_ex));

    assert_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (look_cause == 6'd0) |->
            ((look_kind == 2'd0) ? look_rd : (look_kind == 2'd1) ? look_wr : look_ex));

    assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (look_cause != 6'd0) |->
            (look_paddr == '0 && !look_rd && !look_wr && !look_ex && look_cache == 2'd0));

    assert_offset_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (look_cause == 6'd0) |->
            (look_paddr[PAGE_SHIFT-1:0] == look_vaddr[PAGE_SHIFT-1:0]));

endmodule

bind asid_tlb asid_tlb_checker #(
    .VADDR_W    (VADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .PADDR_W    (PADDR_W)
) u_chk (.*);

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_wr_en = 1'b0;
    logic [1:0]  ent_wr_way = '0;
    logic [1:0]  ent_wr_idx = '0;
    logic [19:0] ent_wr_vpn = '0;
    logic [7:0]  ent_wr_asid = '0;
    logic [19:0] ent_wr_ppn = '0;
    logic [3:0]  ent_wr_attr = '0;
    logic        ring_wr_en = 1'b0;
    logic [31:0] ring_wr_map = '0;
    logic [31:0] look_vaddr = '0;
    logic [1:0]  look_kind = '0;
    logic [1:0]  look_priv = '0;
    logic [31:0] look_paddr;
    logic        look_rd, look_wr, look_ex;
    logic [1:0]  look_cache;
    logic [5:0]  look_cause;

    int total = 0;
    int bad = 0;

    logic [19:0] m_vpn  [4][4];
    logic [7:0]  m_asid [4][4];
    logic [19:0] m_ppn  [4][4];
    logic [3:0]  m_attr [4][4];
    logic [31:0] m_ring;

    always #2.5 clk = ~clk;

    asid_tlb u_asid_tlb (.*);

    // Reference lookup computed from the requirements.
    task automatic model(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv,
                         output logic [31:0] pa, output logic o_r, output logic o_w,
                         output logic o_x, output logic [1:0] cm, output logic [5:0] cause);
        logic [19:0] vpn;
        int idx, nh, sw, sring, rg;
        bit fetch, ar, aw, ax, ok;
        logic [1:0] acm;
        logic [3:0] at;
        vpn = va[31:12];
        idx = int'(vpn[1:0]);
        nh = 0; sw = 0; sring = 0;
        fetch = kind[1];
        for (int w = 0; w < 4; w++) begin
            if (m_asid[w][idx] != 8'd0 && m_vpn[w][idx] == vpn) begin
                rg = -1;
                for (int b = 3; b >= 0; b--)
                    if (m_ring[b*8 +: 8] == m_asid[w][idx]) rg = b;
                if (rg >= 0) begin nh++; sw = w; sring = rg; end
            end
        end
        pa = '0; o_r = 0; o_w = 0; o_x = 0; cm = 2'd0;
        if (nh > 1) cause = fetch ? 6'd17 : 6'd25;
        else if (nh == 0) cause = fetch ? 6'd16 : 6'd24;
        else if (sring < int'(priv)) cause = fetch ? 6'd18 : 6'd26;
        else begin
            at = m_attr[sw][idx];
            ar = 0; aw = 0; ax = 0; acm = 2'd0;
            if (at < 4'd12) begin ar = 1; ax = at[0]; aw = at[1]; acm = at[3:2]; end
            else if (at == 4'd13) begin ar = 1; aw = 1; acm = 2'd3; end
            if (fetch) begin ar = 0; aw = 0; end else ax = 0;
            ok = (kind == 2'd0) ? ar : (kind == 2'd1) ? aw : ax;
            if (!ok) cause = fetch ? 6'd20 : ((kind == 2'd1) ? 6'd29 : 6'd28);
            else begin
                cause = 6'd0;
                pa = {m_ppn[sw][idx], va[11:0]};
                o_r = ar; o_w = aw; o_x = ax; cm = acm;
            end
        end
    endtask

    function automatic string tag_of(input logic [5:0] c);
        case (c)
            6'd16, 6'd24: return "R5";
            6'd17, 6'd25: return "R4";
            6'd18, 6'd26: return "R6";
            6'd20, 6'd28, 6'd29: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Drive a lookup, wait for the combinational result, compare with the model.
    task automatic check_look(input logic [31:0] va, input logic [1:0] kind,
                              input logic [1:0] priv, input string tag);
        logic [31:0] e_pa; logic e_r, e_w, e_x; logic [1:0] e_cm; logic [5:0] e_c;
        @(negedge clk);
        look_vaddr = va; look_kind = kind; look_priv = priv;
        #1;
        model(va, kind, priv, e_pa, e_r, e_w, e_x, e_cm, e_c);
        if (tag == "") tag = tag_of(e_c);
        total++;
        if ({look_paddr, look_rd, look_wr, look_ex, look_cache, look_cause} !==
            {e_pa, e_r, e_w, e_x, e_cm, e_c}) begin
            bad++;
            $display("FAIL %s va=%h kind=%0d priv=%0d got pa=%h rwx=%b%b%b cm=%0d cause=%0d exp pa=%h rwx=%b%b%b cm=%0d cause=%0d",
                     tag, va, kind, priv, look_paddr, look_rd, look_wr, look_ex, look_cache,
                     look_cause, e_pa, e_r, e_w, e_x, e_cm, e_c);
        end
    endtask

    task automatic put_entry(input int way, input int idx, input logic [19:0] vpn,
                             input logic [7:0] asid, input logic [19:0] ppn, input logic [3:0] attr);
        @(negedge clk);
        ent_wr_en = 1'b1; ent_wr_way = 2'(way); ent_wr_idx = 2'(idx);
        ent_wr_vpn = vpn; ent_wr_asid = asid; ent_wr_ppn = ppn; ent_wr_attr = attr;
        @(posedge clk);
        m_vpn[way][idx] = vpn; m_asid[way][idx] = asid;
        m_ppn[way][idx] = ppn; m_attr[way][idx] = attr;
        #1 ent_wr_en = 1'b0;
    endtask

    task automatic put_ring(input logic [31:0] map);
        @(negedge clk);
        ring_wr_en = 1'b1; ring_wr_map = map;
        @(posedge clk);
        m_ring = map;
        #1 ring_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < 4; w++)
            for (int e = 0; e < 4; e++) begin
                m_vpn[w][e] = '0; m_asid[w][e] = '0; m_ppn[w][e] = '0; m_attr[w][e] = '0;
            end
        m_ring = 32'h04030201;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset
        check_look(32'h0000_0000, 2'd0, 2'd0, "R1");
        check_look(32'h1234_5678, 2'd2, 2'd0, "R1");

        // R10 and R9: a single hit with attribute 7 (rwx, write-back)
        put_entry(0, 1, 20'h10001, 8'd1, 20'hABCDE, 4'h7);
        check_look(32'h1000_13C4, 2'd0, 2'd0, "R10");
        check_look(32'h1000_1FFF, 2'd1, 2'd0, "R10");
        check_look(32'h1000_1000, 2'd2, 2'd0, "R9");
        // R1: tag 1 sits in ring 0 after reset, so privilege 1 faults
        check_look(32'h1000_1004, 2'd0, 2'd1, "R1");
        // R1: tag 4 sits in ring 3
        put_entry(1, 2, 20'h10002, 8'd4, 20'h00042, 4'h3);
        check_look(32'h1000_2010, 2'd3, 2'd3, "R1");

        // R2: tag 0 never matches
        put_entry(2, 3, 20'h10003, 8'd0, 20'h11111, 4'h7);
        check_look(32'h1000_3000, 2'd0, 2'd0, "R2");

        // R3: absent tag misses, then becomes ring 2, then lowest duplicate wins
        put_entry(3, 0, 20'h10004, 8'h09, 20'h22222, 4'h2);
        check_look(32'h1000_4008, 2'd0, 2'd0, "R3");
        put_ring(32'h04090201);
        check_look(32'h1000_4008, 2'd1, 2'd2, "R3");
        check_look(32'h1000_4008, 2'd1, 2'd3, "R3");
        put_ring(32'h09030901);
        check_look(32'h1000_4008, 2'd0, 2'd1, "R3");
        check_look(32'h1000_4008, 2'd0, 2'd2, "R3");
        put_ring(32'h04030201);

        // R4: two valid hits; a third copy with an unmapped tag does not count
        put_entry(1, 1, 20'h20005, 8'd1, 20'h33333, 4'h4);
        put_entry(2, 1, 20'h20005, 8'd2, 20'h44444, 4'h4);
        check_look(32'h2000_5000, 2'd0, 2'd0, "R4");
        check_look(32'h2000_5000, 2'd3, 2'd0, "R4");
        put_entry(2, 1, 20'h20005, 8'd5, 20'h44444, 4'h4);
        check_look(32'h2000_5ABC, 2'd0, 2'd0, "R4");

        // R11: wrong index is never found; correct index is
        put_entry(3, 2, 20'h30001, 8'd1, 20'h55555, 4'h4);
        check_look(32'h3000_1000, 2'd0, 2'd0, "R11");
        put_entry(3, 1, 20'h30001, 8'd1, 20'h66666, 4'h4);
        check_look(32'h3000_1123, 2'd0, 2'd0, "R11");

        // R6: ring 2 page, privilege boundary checked before rights
        put_entry(1, 3, 20'h50003, 8'd3, 20'h77777, 4'h4);
        check_look(32'h5000_3000, 2'd0, 2'd2, "R6");
        check_look(32'h5000_3000, 2'd0, 2'd3, "R6");
        check_look(32'h5000_3000, 2'd2, 2'd3, "R6");

        // R7 / R8 / R9: full attribute sweep on every access kind
        for (int a = 0; a < 16; a++) begin
            put_entry(0, 3, 20'h40007, 8'd1, 20'h5A5A5, 4'(a));
            for (int k = 0; k < 4; k++)
                check_look(32'h4000_7ABC, 2'(k), 2'd0, (a < 12) ? "R7" : "R8");
        end

        // Random mix of writes, ring map changes and lookups
        for (int it = 0; it < 1500; it++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 3) begin
                logic [19:0] v;
                int ix;
                v = {16'h7000, 4'($urandom)};
                ix = ($urandom % 8 == 0) ? int'($urandom % 4) : int'(v[1:0]);
                put_entry(int'($urandom % 4), ix, v, 8'($urandom % 6), 20'($urandom),
                          4'($urandom));
            end else if (r == 3 && ($urandom % 4 == 0)) begin
                put_ring({8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6)});
            end else begin
                check_look({16'h7000, 4'($urandom), 12'($urandom)}, 2'($urandom),
                           2'($urandom), "");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule